// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file for a processor whose procedures each see a small, fixed set of logical registers. The set is a view into a larger circular array of physical registers. Each window has three eight-register groups: incoming arguments, locals and outgoing arguments. The outgoing group of one window is the same storage as the incoming group of the next window. A caller leaves its arguments in its outgoing registers, raises a call strobe, and the callee finds them in its incoming registers. No data is copied.

The current window pointer moves forward on a call and back on a return. The block keeps count of how many windows hold live frames. A call with the array full raises an overflow: the oldest resident frame (its incoming and local groups) is streamed out one word per handshake, and then the call completes. A return with only the current frame resident raises an underflow: the caller's frame is streamed back in, and then the return completes. Two read ports and one write port are addressed by logical register number. Reads are combinational and writes take effect at the clock edge.

Top module: `rwin_file`

## Requirements
- R1: After reset the window pointer is 0, one window is resident, busy, overflow and underflow are low, and every register reads as zero.
- R2: With window pointer w, logical indices 0 to 15 address physical entry w*16+i. Indices 16 to 23 address ((w+1)*16+i-16) mod 128. A value written to outgoing register 16+j before a call is therefore read as incoming register j after it.
- R3: While not busy, a call moves the window pointer to (w+1) mod 8 and a return moves it to (w-1) mod 8, visible on the next cycle. When both strobes are high, the call wins and the return is dropped.
- R4: A call while 7 windows are resident makes busy and overflow high from the next cycle. The block then offers window (w+2) mod 8, logical indices 0 to 15 in ascending order, one word per accepted valid/ready handshake. After the last word the pointer becomes (w+1) mod 8 and the resident count is unchanged.
- R5: A return while 1 window is resident makes busy and underflow high from the next cycle. The block then accepts window (w-1) mod 8, logical indices 0 to 15 in ascending order, one word per handshake. After the last word the pointer becomes (w-1) mod 8.
- R6: Call and return strobes that arrive while busy are ignored.
- R7: Read data follows the address in the same cycle. A write commits at the clock edge, so a read of the entry being written in that cycle returns the old value.
- R8: Logical indices 24 to 31 read as zero, and writes to them change no register.
- R9: While spill data is offered and not accepted, the offered word, index and window stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| busy_o | output | 1 | Spill or fill in progress |
| overflow_o | output | 1 | Spill of the oldest window in progress |
| underflow_o | output | 1 | Fill of the caller window in progress |
| cwp_o | output | 3 | Current window pointer |
| ra_addr_i | input | 5 | Read port A logical index |
| ra_data_o | output | 32 | Read port A data |
| rb_addr_i | input | 5 | Read port B logical index |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Write logical index |
| wd_i | input | 32 | Write data |
| spill_valid_o | output | 1 | Spill word offered |
| spill_ready_i | input | 1 | Spill word accepted |
| spill_data_o | output | 32 | Spill word |
| xfer_win_o | output | 3 | Window being spilled or filled |
| xfer_idx_o | output | 4 | Logical index of the word being transferred |
| fill_valid_i | input | 1 | Fill word present |
| fill_ready_o | output | 1 | Fill word accepted |
| fill_data_i | input | 32 | Fill word |

## Verification
A wrong window pointer shows up at once, because every read returns the wrong physical entry, so the bench compares both read ports on every cycle against its own model of the array. A wrong resident count is only visible at the next call or return near the limits: the bench sees overflow or underflow one transfer too early or too late. A wrong spill target, order or data shows up on the first transferred word, and a corrupt fill shows up on the first read of the restored frame after the return completes. Call-heavy and return-heavy random phases wrap the buffer many times, so errors in the modulo arithmetic of the mapping surface within a few hundred cycles.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } rwin_state_e;
endpackage

// File: rtl/rwin_map.sv
module rwin_map #(
  parameter  int NWIN = 8,
  parameter  int NREG = 8,
  localparam int WW   = $clog2(NWIN),
  localparam int LW   = $clog2(3 * NREG),
  localparam int PW   = $clog2(NWIN * 2 * NREG)
) (
  input  logic [WW-1:0] cwp_i,
  input  logic [LW-1:0] lidx_i,
  output logic [PW-1:0] pidx_o,
  output logic          valid_o
);
  localparam int STRIDE = 2 * NREG;
  localparam int NPHYS  = NWIN * STRIDE;

  always_comb begin
    int t;
    valid_o = int'(lidx_i) < 3 * NREG;
    if (int'(lidx_i) < STRIDE) t = int'(cwp_i) * STRIDE + int'(lidx_i);
    else                       t = (int'(cwp_i) + 1) * STRIDE + int'(lidx_i) - STRIDE;
    pidx_o = PW'(t % NPHYS);
  end
endmodule

// File: rtl/rwin_array.sv
module rwin_array #(
  parameter int DW    = 32,
  parameter int NPHYS = 128,
  parameter int NRP   = 3,
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_a_i,
  input  logic [PW-1:0] wa_a_i,
  input  logic [DW-1:0] wd_a_i,
  input  logic          we_b_i,
  input  logic [PW-1:0] wa_b_i,
  input  logic [DW-1:0] wd_b_i,
  input  logic [PW-1:0] raddr_i [NRP],
  output logic [DW-1:0] rdata_o [NRP]
);
  logic [DW-1:0] mem_q [NPHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
    end else begin
      // port b (fill) wins a same-entry collision
      if (we_a_i && !(we_b_i && wa_b_i == wa_a_i)) mem_q[wa_a_i] <= wd_a_i;
      if (we_b_i) mem_q[wa_b_i] <= wd_b_i;
    end
  end

  for (genvar k = 0; k < NRP; k++) begin : g_rd
    assign rdata_o[k] = mem_q[raddr_i[k]];
  end

  assert_write_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_b_i) |=> (mem_q[$past(wa_b_i)] == $past(wd_b_i)));
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter  int NWIN = 8,
  parameter  int NREG = 8,
  localparam int WW   = $clog2(NWIN),
  localparam int XW   = $clog2(2 * NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          spill_ready_i,
  input  logic          fill_valid_i,
  output logic [WW-1:0] cwp_o,
  output logic          busy_o,
  output logic          overflow_o,
  output logic          underflow_o,
  output logic          spill_valid_o,
  output logic          fill_ready_o,
  output logic          fill_we_o,
  output logic [WW-1:0] xwin_o,
  output logic [XW-1:0] xidx_o
);
  localparam logic [WW-1:0] RC_MAX = WW'(NWIN - 1);
  localparam logic [WW-1:0] RC_ONE = WW'(1);
  localparam logic [XW-1:0] LAST   = XW'(2 * NREG - 1);

  rwin_state_e   st_q;
  logic [WW-1:0] cwp_q, rc_q, xwin_q;
  logic [XW-1:0] cnt_q;
  logic          xfer_go, xfer_done;

  assign xfer_go   = (st_q == ST_SPILL && spill_ready_i) || (st_q == ST_FILL && fill_valid_i);
  assign xfer_done = xfer_go && cnt_q == LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cwp_q  <= '0;
      rc_q   <= RC_ONE;
      xwin_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (call_i) begin
            if (rc_q == RC_MAX) begin
              st_q   <= ST_SPILL;
              xwin_q <= cwp_q + WW'(2);  // oldest resident frame
              cnt_q  <= '0;
            end else begin
              cwp_q <= cwp_q + WW'(1);
              rc_q  <= rc_q + WW'(1);
            end
          end else if (ret_i) begin
            if (rc_q == RC_ONE) begin
              st_q   <= ST_FILL;
              xwin_q <= cwp_q - WW'(1);
              cnt_q  <= '0;
            end else begin
              cwp_q <= cwp_q - WW'(1);
              rc_q  <= rc_q - WW'(1);
            end
          end
        end
        ST_SPILL, ST_FILL: begin
          if (xfer_go) cnt_q <= cnt_q + XW'(1);
          if (xfer_done) begin
            st_q  <= ST_IDLE;
            cwp_q <= (st_q == ST_SPILL) ? cwp_q + WW'(1) : cwp_q - WW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cwp_o         = cwp_q;
  assign busy_o        = st_q != ST_IDLE;
  assign overflow_o    = st_q == ST_SPILL;
  assign underflow_o   = st_q == ST_FILL;
  assign spill_valid_o = st_q == ST_SPILL;
  assign fill_ready_o  = st_q == ST_FILL;
  assign fill_we_o     = fill_ready_o && fill_valid_i;
  assign xwin_o        = xwin_q;
  assign xidx_o        = cnt_q;

  assert_call_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && call_i && rc_q != RC_MAX) |=> (cwp_o == $past(cwp_o) + WW'(1)));
  assert_ret_back_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !call_i && ret_i && rc_q != RC_ONE) |=> (cwp_o == $past(cwp_o) - WW'(1)));
  assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !xfer_done) |=> (busy_o && $stable(cwp_o)));
  assert_rc_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rc_q >= RC_ONE && rc_q <= RC_MAX));
  assert_spill_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_valid_o && spill_ready_i && xidx_o != LAST) |=> (spill_valid_o && xidx_o == $past(xidx_o) + XW'(1)));
endmodule

// File: rtl/rwin_file.sv
module rwin_file #(
  parameter  int NWIN = 8,
  parameter  int NREG = 8,
  parameter  int DW   = 32,
  localparam int WW   = $clog2(NWIN),
  localparam int LW   = $clog2(3 * NREG),
  localparam int XW   = $clog2(2 * NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  output logic          busy_o,
  output logic          overflow_o,
  output logic          underflow_o,
  output logic [WW-1:0] cwp_o,
  input  logic [LW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [LW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o,
  input  logic          we_i,
  input  logic [LW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  output logic          spill_valid_o,
  input  logic          spill_ready_i,
  output logic [DW-1:0] spill_data_o,
  output logic [WW-1:0] xfer_win_o,
  output logic [XW-1:0] xfer_idx_o,
  input  logic          fill_valid_i,
  output logic          fill_ready_o,
  input  logic [DW-1:0] fill_data_i
);
  localparam int NPHYS = NWIN * 2 * NREG;
  localparam int PW    = WW + XW;
  localparam int NMAP  = 3;  // read a, read b, write

  logic [WW-1:0] cwp;
  logic [WW-1:0] xwin;
  logic [XW-1:0] xidx;
  logic          fill_we;
  logic [LW-1:0] lidx  [NMAP];
  logic [PW-1:0] pidx  [NMAP];
  logic          lvld  [NMAP];
  logic [PW-1:0] raddr [3];
  logic [DW-1:0] rdata [3];

  assign lidx[0] = ra_addr_i;
  assign lidx[1] = rb_addr_i;
  assign lidx[2] = wa_i;

  for (genvar k = 0; k < NMAP; k++) begin : g_map
    rwin_map #(.NWIN(NWIN), .NREG(NREG)) u_map (
      .cwp_i  (cwp),
      .lidx_i (lidx[k]),
      .pidx_o (pidx[k]),
      .valid_o(lvld[k])
    );
  end

  rwin_ctrl #(.NWIN(NWIN), .NREG(NREG)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .spill_ready_i(spill_ready_i),
    .fill_valid_i (fill_valid_i),
    .cwp_o        (cwp),
    .busy_o       (busy_o),
    .overflow_o   (overflow_o),
    .underflow_o  (underflow_o),
    .spill_valid_o(spill_valid_o),
    .fill_ready_o (fill_ready_o),
    .fill_we_o    (fill_we),
    .xwin_o       (xwin),
    .xidx_o       (xidx)
  );

  assign raddr[0] = pidx[0];
  assign raddr[1] = pidx[1];
  assign raddr[2] = {xwin, xidx};

  rwin_array #(.DW(DW), .NPHYS(NPHYS), .NRP(3)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_a_i (we_i && lvld[2]),
    .wa_a_i (pidx[2]),
    .wd_a_i (wd_i),
    .we_b_i (fill_we),
    .wa_b_i ({xwin, xidx}),
    .wd_b_i (fill_data_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  assign ra_data_o    = lvld[0] ? rdata[0] : '0;
  assign rb_data_o    = lvld[1] ? rdata[1] : '0;
  assign spill_data_o = rdata[2];
  assign cwp_o        = cwp;
  assign xfer_win_o   = xwin;
  assign xfer_idx_o   = xidx;

  assert_spill_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_valid_o && !spill_ready_i) |=>
      (spill_valid_o && $stable(spill_data_o) && $stable(xfer_idx_o) && $stable(xfer_win_o)));
  assert_invalid_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i >= LW'(3 * NREG)) |-> (ra_data_o == '0));
endmodule

// File: tb/rwin_file_test.sv
`timescale 1ns/1ps
module rwin_file_test;
  localparam int NW = 8;
  localparam int NP = 128;
  localparam int SD = 256;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        call_i = 0, ret_i = 0, we_i = 0;
  logic [4:0]  ra_addr_i = 0, rb_addr_i = 0, wa_i = 0;
  logic [31:0] wd_i = 0, fill_data_i = 0;
  logic        spill_ready_i = 0, fill_valid_i = 0;
  logic        busy_o, overflow_o, underflow_o, spill_valid_o, fill_ready_o;
  logic [2:0]  cwp_o, xfer_win_o;
  logic [3:0]  xfer_idx_o;
  logic [31:0] ra_data_o, rb_data_o, spill_data_o;

  always #2.5 clk_i = ~clk_i;

  rwin_file uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i),
    .busy_o(busy_o), .overflow_o(overflow_o), .underflow_o(underflow_o), .cwp_o(cwp_o),
    .ra_addr_i(ra_addr_i), .ra_data_o(ra_data_o), .rb_addr_i(rb_addr_i), .rb_data_o(rb_data_o),
    .we_i(we_i), .wa_i(wa_i), .wd_i(wd_i),
    .spill_valid_o(spill_valid_o), .spill_ready_i(spill_ready_i), .spill_data_o(spill_data_o),
    .xfer_win_o(xfer_win_o), .xfer_idx_o(xfer_idx_o),
    .fill_valid_i(fill_valid_i), .fill_ready_o(fill_ready_o), .fill_data_i(fill_data_i)
  );

  int errors = 0, checks = 0;
  int n_spill = 0, n_fill = 0;
  logic [31:0] phys [NP];
  logic [31:0] stk [SD][16];
  int sp, m_cwp, m_rc, m_st, m_xwin, m_cnt;
  bit prev_wait;
  logic [31:0] prev_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_phys(int w, int l);
    if (l < 16) return w * 16 + l;
    return ((w + 1) * 16 + l - 16) % NP;
  endfunction

  function automatic logic [31:0] exp_read(int l);
    if (l >= 24) return 32'h0;
    return phys[exp_phys(m_cwp, l)];
  endfunction

  function automatic logic [31:0] fill_word();
    if (sp > 0) return stk[sp-1][m_cnt];
    return 32'hF000_0000 | (m_xwin << 8) | m_cnt;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    call_i = 0; ret_i = 0; we_i = 0;
    for (int i = 0; i < NP; i++) phys[i] = '0;
    m_cwp = 0; m_rc = 1; m_st = 0; m_xwin = 0; m_cnt = 0; sp = 0; prev_wait = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic step(input bit c, input bit r, input bit w, input int wa, input logic [31:0] wd,
                      input int a, input int b);
    bit fv, sr;
    @(negedge clk_i);
    call_i = c; ret_i = r; we_i = w; wa_i = 5'(wa); wd_i = wd;
    ra_addr_i = 5'(a); rb_addr_i = 5'(b);
    sr = ($urandom % 4) != 0;
    fv = ($urandom % 4) != 0;
    spill_ready_i = sr; fill_valid_i = fv;
    fill_data_i = fill_word();
    #1;
    chk(ra_data_o == exp_read(a), "R7 read A", ra_data_o, exp_read(a));
    chk(rb_data_o == exp_read(b), "R7 read B", rb_data_o, exp_read(b));
    chk(cwp_o == 3'(m_cwp), "R3 R6 window pointer", 32'(cwp_o), 32'(m_cwp));
    chk(busy_o == (m_st != 0), "R6 busy", 32'(busy_o), 32'(m_st != 0));
    chk(overflow_o == (m_st == 1), "R4 overflow", 32'(overflow_o), 32'(m_st == 1));
    chk(underflow_o == (m_st == 2), "R5 underflow", 32'(underflow_o), 32'(m_st == 2));
    if (m_st == 1) begin
      chk(spill_valid_o && xfer_win_o == 3'(m_xwin) && xfer_idx_o == 4'(m_cnt), "R4 spill slot",
          {spill_valid_o, 4'(xfer_win_o), 4'(xfer_idx_o)}, {1'b1, 4'(m_xwin), 4'(m_cnt)});
      chk(spill_data_o == phys[m_xwin*16 + m_cnt], "R4 spill data", spill_data_o, phys[m_xwin*16 + m_cnt]);
      if (prev_wait) chk(spill_data_o == prev_data, "R9 spill hold", spill_data_o, prev_data);
    end
    if (m_st == 2)
      chk(fill_ready_o && xfer_win_o == 3'(m_xwin) && xfer_idx_o == 4'(m_cnt), "R5 fill slot",
          {fill_ready_o, 4'(xfer_win_o), 4'(xfer_idx_o)}, {1'b1, 4'(m_xwin), 4'(m_cnt)});
    prev_wait = (m_st == 1) && !sr;
    prev_data = spill_data_o;
    // model update for the coming edge
    if (m_st == 1 && sr) stk[sp][m_cnt] = phys[m_xwin*16 + m_cnt];
    if (w && wa < 24) phys[exp_phys(m_cwp, wa)] = wd;
    if (m_st == 2 && fv) phys[m_xwin*16 + m_cnt] = fill_data_i;
    case (m_st)
      0: if (c) begin
           if (m_rc == NW - 1) begin m_st = 1; m_xwin = (m_cwp + 2) % NW; m_cnt = 0; end
           else begin m_cwp = (m_cwp + 1) % NW; m_rc++; end
         end else if (r) begin
           if (m_rc == 1) begin m_st = 2; m_xwin = (m_cwp + NW - 1) % NW; m_cnt = 0; end
           else begin m_cwp = (m_cwp + NW - 1) % NW; m_rc--; end
         end
      1: if (sr) begin
           if (m_cnt == 15) begin m_st = 0; m_cwp = (m_cwp + 1) % NW; sp++; n_spill++; end
           else m_cnt++;
         end
      2: if (fv) begin
           if (m_cnt == 15) begin m_st = 0; m_cwp = (m_cwp + NW - 1) % NW; if (sp > 0) sp--; n_fill++; end
           else m_cnt++;
         end
      default: ;
    endcase
  endtask

  task automatic idle_until_free();
    while (m_st != 0) step(($urandom % 3) == 0, ($urandom % 3) == 0, 0, 0, 0, $urandom % 24, $urandom % 24);
  endtask

  task automatic rand_phase(input int n, input int pcall, input int pret);
    for (int i = 0; i < n; i++) begin
      int roll = $urandom % 100;
      bit c = roll < pcall && sp < SD - 4;
      bit r = !c && roll < pcall + pret;
      step(c, r, ($urandom % 2) == 1, $urandom % 32, $urandom, $urandom % 32, $urandom % 32);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    $display("FAIL watchdog expired actual=running expected=done");
    errors++; checks++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7041));
    do_reset();
    #1;
    chk(!busy_o && !overflow_o && !underflow_o && cwp_o == 0, "R1 reset outputs",
        {busy_o, overflow_o, underflow_o, 1'b0, 4'(cwp_o)}, 32'h0);
    for (int l = 0; l < 24; l++) step(0, 0, 0, 0, 0, l, 23 - l);  // R1 all zero

    // R7: same-cycle write and read returns old value, new value next cycle
    step(0, 0, 1, 5, 32'hAAAA_0005, 5, 5);
    chk(ra_data_o == 32'h0, "R7 old value in write cycle", ra_data_o, 32'h0);
    step(0, 0, 0, 0, 0, 5, 0);
    chk(ra_data_o == 32'hAAAA_0005, "R7 committed value", ra_data_o, 32'hAAAA_0005);

    // R8: out-of-range index
    step(0, 0, 1, 24, 32'hDEAD_BEEF, 24, 31);
    chk(ra_data_o == 0 && rb_data_o == 0, "R8 invalid read", ra_data_o | rb_data_o, 32'h0);
    for (int l = 0; l < 24; l++) step(0, 0, 0, 0, 0, l, l);

    // R2: outgoing of caller appears as incoming of callee
    step(0, 0, 1, 19, 32'h1900_0013, 0, 0);
    step(0, 0, 1, 8, 32'h0800_0008, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 3, 8);
    chk(cwp_o == 1, "R3 call advance", 32'(cwp_o), 32'd1);
    chk(ra_data_o == 32'h1900_0013, "R2 overlap", ra_data_o, 32'h1900_0013);
    chk(rb_data_o == 32'h0, "R2 locals private", rb_data_o, 32'h0);

    // R3: call wins over return
    step(1, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(cwp_o == 2, "R3 call priority", 32'(cwp_o), 32'd2);

    // R4: directed overflow from reset
    do_reset();
    for (int i = 0; i < 6; i++) step(1, 0, 1, 16 + i, 32'h6600_0000 + i, 0, 0);
    step(0, 0, 1, 9, 32'h0900_0009, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(overflow_o && xfer_win_o == 0, "R4 overflow target", {overflow_o, 4'(xfer_win_o)}, {1'b1, 4'd0});
    idle_until_free();
    step(0, 0, 0, 0, 0, 9, 0);
    chk(cwp_o == 7 && !overflow_o, "R4 call completes", {overflow_o, 4'(cwp_o)}, {1'b0, 4'd7});

    // R5: directed underflow from reset
    do_reset();
    step(0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);  // R6 ignored while busy
    chk(underflow_o && xfer_win_o == 7, "R5 underflow target", {underflow_o, 4'(xfer_win_o)}, {1'b1, 4'd7});
    idle_until_free();
    step(0, 0, 0, 0, 0, 3, 12);
    chk(cwp_o == 7 && !underflow_o, "R5 return completes", {underflow_o, 4'(cwp_o)}, {1'b0, 4'd7});

    // random phases: deep calls, deep returns, mixed
    do_reset();
    rand_phase(4000, 40, 10);
    rand_phase(4000, 10, 40);
    rand_phase(4000, 20, 20);
    rand_phase(2000, 40, 10);
    rand_phase(4000, 5, 45);
    chk(n_spill > 0, "R4 spills exercised", n_spill, 1);
    chk(n_fill > 0, "R5 fills exercised", n_fill, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule